// File: doc/BRIEF.md
# Column-Wise Line-Buffer Convolution

This block applies a K-tap filter down the columns of a raster image that arrives one sample per clock in row-major order. It keeps only the previous K-1 rows in small column-indexed line memories, not a whole frame. Every accepted sample is weighted together with the K-1 samples directly above it in the same column. The line memories then shift up by one row in that column: the oldest value is dropped, and the new sample becomes the most recent stored row.

Row length and frame height are run-time inputs. The row length is normally the number of samples that a preceding horizontal stage produces per row. The block tracks its own column and row position and returns to the top-left corner after the last sample of a frame, so frames can follow one another with no gap. Because no result is produced for the first K-1 rows of a frame, the line memories never need clearing. Stale contents from before reset or from an earlier frame never reach the output.

Top module: `vconv_linebuf`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `out_valid` is 0. A reset in the middle of a frame returns the position to column 0, row 0.
- R2: A sample accepted (`in_valid`=1) in row r ≥ K-1 produces `out_valid`=1 with its result exactly one clock later. Samples in rows 0 to K-2 produce no output.
- R3: The result for the sample at row r, column c equals the sum over i=0..K-1 of coef[i] × pixel(r-(K-1)+i, c). Tap K-1 is the incoming sample itself.
- R4: Coefficient i occupies bits [i*CW +: CW] of `coef`, unsigned. Coefficient 0 weights the oldest stored row, and coefficient K-1 weights the incoming sample.
- R5: A cycle with `in_valid`=0 produces no output and leaves the position and the stored rows unchanged. Gaps in the stream therefore do not change any later result.
- R6: The column wraps to 0 after `row_len` accepted samples, and the row wraps to 0 after `num_rows` rows. The next frame then again suppresses its first K-1 rows, and its results use only its own samples.
- R7: Results are full precision (OW = DW+CW+clog2(K) bits), so all-ones samples with all-ones coefficients give K×(2^DW-1)×(2^CW-1) with no truncation.
- R8: `row_len` may change between frames to any value from 1 to MAX_W. Each column is filtered independently of its neighbours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_len | input | clog2(MAX_W+1) | Samples per row, 1..MAX_W |
| num_rows | input | clog2(MAX_H+1) | Rows per frame, 1..MAX_H |
| coef | input | K*CW | Packed vertical coefficients, tap 0 in the low bits |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | DW | Input sample |
| out_valid | output | 1 | Result qualifier |
| out_data | output | OW | Filter result |

## Verification
Every result is due exactly one clock after the accepted sample that completes it, because a single output register sits between input and output. The bench drives each sample on a falling edge and checks `out_valid` and `out_data` on the next falling edge, which is half a period after the capturing edge. Idle cycles and suppressed rows are checked in the same cycle slot, where `out_valid` must be 0. Expected sums come from a per-frame pixel model kept in the bench, so a wrong row order, a lost shift or stale data shows up as a value mismatch.

// File: rtl/vconv_linebuf.sv
module vconv_linebuf #(
  parameter int DW    = 8,
  parameter int CW    = 8,
  parameter int K     = 3,
  parameter int MAX_W = 16,
  parameter int MAX_H = 16,
  localparam int XW = $clog2(MAX_W + 1),
  localparam int YW = $clog2(MAX_H + 1),
  localparam int AW = (MAX_W > 1) ? $clog2(MAX_W) : 1,
  localparam int OW = DW + CW + $clog2(K)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XW-1:0]   row_len,
  input  logic [YW-1:0]   num_rows,
  input  logic [K*CW-1:0] coef,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_data,
  output logic            out_valid,
  output logic [OW-1:0]   out_data
);

  logic [DW-1:0] line_q [K-1][MAX_W];
  logic [DW-1:0] tap [K];
  logic [AW-1:0] col;
  logic [YW-1:0] row;
  logic [OW-1:0] acc;
  logic last_col, last_row, live_row;

  assign last_col = (XW'(col) + XW'(1)) == row_len;
  assign last_row = (row + YW'(1)) == num_rows;
  assign live_row = row >= YW'(K - 1);

  for (genvar i = 0; i < K - 1; i++) begin : g_tap
    assign tap[i] = line_q[i][col];
  end
  assign tap[K-1] = in_data;

  always_comb begin
    acc = '0;
    for (int i = 0; i < K; i++)
      acc = acc + OW'(tap[i]) * OW'(coef[i*CW +: CW]);
  end

  always_ff @(posedge clk) begin
    if (in_valid)
      for (int i = 1; i < K; i++) line_q[i-1][col] <= tap[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
      out_valid <= 1'b0;
      out_data <= '0;
    end else begin
      out_valid <= in_valid && live_row;
      if (in_valid && live_row) out_data <= acc;
      if (in_valid) begin
        if (last_col) begin
          col <= '0;
          row <= last_row ? '0 : row + YW'(1);
        end else begin
          col <= col + AW'(1);
        end
      end
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  a_r2_early_rows_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && row < YW'(K - 1)) |=> !out_valid);

  a_r2_result_due: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && row >= YW'(K - 1)) |=> out_valid);

  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(col) && $stable(row)));

  a_r6_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && last_col) |=> (col == '0));

  a_r6_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && last_col && last_row) |=> (row == '0));

endmodule

// File: tb/tb_vconv_linebuf.sv
module tb_vconv_linebuf;
  localparam int DW = 8, CW = 8, K = 3, MAX_W = 16, MAX_H = 16;
  localparam int XW = $clog2(MAX_W + 1), YW = $clog2(MAX_H + 1);
  localparam int OW = DW + CW + $clog2(K);

  // width, height, coef0, coef1, coef2, seed, gap
  localparam int NCFG = 6;
  localparam int CFG [NCFG][7] = '{
    '{4,  5, 1, 2, 1, 3, 0},
    '{6,  4, 3, 0, 0, 7, 0},
    '{1,  6, 0, 0, 5, 2, 0},
    '{16, 3, 1, 1, 1, 9, 0},
    '{5,  4, 2, 5, 7, 4, 1},
    '{3,  3, 255, 255, 255, 0, 0}
  };

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [XW-1:0] row_len = '0;
  logic [YW-1:0] num_rows = '0;
  logic [K*CW-1:0] coef = '0;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic [OW-1:0] out_data;

  int total = 0, bad = 0;
  int pix [MAX_H][MAX_W];
  int cf [K];

  always #2.5 clk = ~clk;

  vconv_linebuf #(.DW(DW), .CW(CW), .K(K), .MAX_W(MAX_W), .MAX_H(MAX_H)) dut (
    .clk(clk), .rst_n(rst_n), .row_len(row_len), .num_rows(num_rows), .coef(coef),
    .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one cycle at a falling edge, return at the next falling edge
  task automatic step(input logic v, input int d);
    in_valid = v;
    in_data = DW'(d);
    @(negedge clk);
  endtask

  task automatic run_frame(input int w, input int h, input int seed, input int gap,
                           input int fixed);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        longint exp;
        pix[r][c] = (fixed >= 0) ? fixed : ((seed * 37 + r * 11 + c * 5 + r * c * 3) & 255);
        step(1'b1, pix[r][c]);
        if (r < K - 1) begin
          check("R2 early row silent", out_valid, 0);
        end else begin
          exp = 0;
          for (int i = 0; i < K; i++) exp += longint'(cf[i]) * pix[r - (K - 1) + i][c];
          check("R2 result valid", out_valid, 1);
          check("R3 column sum", out_data, exp);
        end
        if (gap != 0) begin
          step(1'b0, 8'hA5);
          check("R5 idle no output", out_valid, 0);
        end
      end
    step(1'b0, 0);
  endtask

  task automatic set_cfg(input int w, input int h, input int c0, input int c1, input int c2);
    row_len = XW'(w);
    num_rows = YW'(h);
    cf[0] = c0; cf[1] = c1; cf[2] = c2;
    coef = {CW'(c2), CW'(c1), CW'(c0)};
  endtask

  initial begin
    #20000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 reset out_valid", out_valid, 0);
    rst_n = 1;
    check("R1 first cycle after reset", out_valid, 0);

    for (int t = 0; t < NCFG; t++) begin
      set_cfg(CFG[t][0], CFG[t][1], CFG[t][2], CFG[t][3], CFG[t][4]);
      // R4 (coef order), R6 (back-to-back frames), R8 (width changes) via table
      run_frame(CFG[t][0], CFG[t][1], CFG[t][5], CFG[t][6], (t == NCFG - 1) ? 255 : -1);
    end

    // R7 full scale: last table row gives 3*255*255 in its final row
    check("R7 full scale last value", out_data, 3 * 255 * 255);

    // R1 mid-frame reset: partial frame, reset, then a clean frame
    set_cfg(4, 4, 1, 3, 9);
    for (int i = 0; i < 6; i++) step(1'b1, 200);
    rst_n = 0;
    step(1'b0, 0);
    check("R1 reset during frame", out_valid, 0);
    rst_n = 1;
    run_frame(4, 4, 5, 0, -1);

    // R4 single weight on newest row only
    set_cfg(2, 3, 0, 0, 1);
    run_frame(2, 3, 11, 1, -1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule